// File: doc/BRIEF.md
# Tree-Structured Mismatch-Shaping Encoder

This block drives an array of equally weighted one-bit DAC elements from a binary count. A count from 0 to 8 enters a binary tree of switching nodes three layers deep. The root node splits the count into two halves, the next layer splits each half again, and the bottom layer produces single-bit element controls. The result is an 8-bit element vector whose number of ones equals the count.

When a node receives an odd value, one of its two outputs must get one unit more than the other. Each node keeps a one-bit sign register, and the favoured side alternates from one odd input to the next. Each node's split error therefore forms a first-order sequence of +1, 0 and -1 whose nonzero values alternate in sign. This pushes the mismatch error of the elements towards high frequencies. The start sign of each node after reset is taken from a bit of a 16-bit LFSR sequence chosen by a seed parameter, so the nodes do not all start in step.

A new count is accepted on a cycle with the valid strobe high. Its element vector is registered and appears one clock later. The vector holds its value while the strobe is low.

Top module: `tree_shaper_enc`

## Requirements
- R1: While reset is high, and on the first clock after it, the element vector is all zeros.
- R2: One clock after a cycle with in_valid high, the number of ones in elem equals the in_count of that cycle.
- R3: While in_valid is low, elem keeps its value and in_count has no effect on it.
- R4: The node at depth d (root at depth 0) and position i covers elements i*2^k to i*2^k+2^k-1, where k = 3-d. Its lower output drives the lower half of that range and its upper output drives the upper half. The ones in the two halves differ by at most one.
- R5: When a node receives an odd value, its two halves differ by exactly one. Take the sign as (lower minus upper). That sign alternates between successive odd inputs to the same node.
- R6: When a node receives an even value, its two halves are equal, and the node's alternation state is left unchanged.
- R7: Eight consecutive accepted counts of 1 turn on every element exactly once. Eight consecutive counts of 7 leave every element off exactly once.
- R8: A count on in_count above 8 is outside the legal input range and is never presented with in_valid high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept in_count this cycle |
| in_count | input | 4 | Number of elements to turn on, 0 to 8 |
| elem | output | 8 | Registered one-bit element controls |

## Verification
The assertions take for granted that in_count never exceeds 8 on a cycle with in_valid high (R8). A count of 9 to 15 would overflow the root's halves, so the sum and balance properties would not hold for it. The stimulus respects this in two ways. It draws every accepted count from 0 to 8, covering all ordered pairs of such counts as well as random sequences. It presents out-of-range values only on idle cycles, where they also serve to test that in_count is ignored.

// File: rtl/tse_pkg.sv
package tse_pkg;

  // Bit offset of depth d inside the level-packed split bus.
  // Depth e holds 2^e fields, each (layers-e+1) bits wide.
  function automatic int lvl_off(input int layers, input int d);
    int acc;
    acc = 0;
    for (int e = 0; e < d; e++) acc += (1 << e) * (layers - e + 1);
    return acc;
  endfunction

  // Start sign for the node with heap index idx: a bit of a 16-bit LFSR run.
  function automatic logic seed_bit(input logic [15:0] seed, input int idx);
    logic [15:0] s;
    s = seed | 16'h0001;
    for (int n = 0; n <= idx; n++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    return s[0];
  endfunction

endpackage

// File: rtl/tse_node.sv
module tse_node #(
  parameter int W        = 1,    // output width; input is W+1 bits
  parameter bit INIT_POS = 1'b0  // favoured side after reset (1 = lower)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W:0]   x,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic         pos_q;
  logic [W-1:0] half;

  assign half = x[W:1];
  assign lo   = half + W'(x[0] & pos_q);
  assign hi   = half + W'(x[0] & ~pos_q);

  always_ff @(posedge clk) begin
    if (rst)            pos_q <= INIT_POS;
    else if (en && x[0]) pos_q <= ~pos_q;
  end
endmodule

// File: rtl/tse_tree.sv
module tse_tree #(
  parameter int          LAYERS = 3,
  parameter logic [15:0] SEED   = 16'hACE1,
  localparam int         N      = 1 << LAYERS,
  localparam int         CW     = LAYERS + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] count,
  output logic [N-1:0]  elem_nxt
);
  localparam int TOTAL = tse_pkg::lvl_off(LAYERS, LAYERS + 1);

  logic [TOTAL-1:0] flat;

  assign flat[CW-1:0] = count;

  for (genvar d = 0; d < LAYERS; d++) begin : g_depth
    localparam int K = LAYERS - d;
    for (genvar i = 0; i < (1 << d); i++) begin : g_node
      localparam int IN_LO  = tse_pkg::lvl_off(LAYERS, d) + i * (K + 1);
      localparam int OUT_LO = tse_pkg::lvl_off(LAYERS, d + 1) + 2 * i * K;
      tse_node #(
        .W        (K),
        .INIT_POS (tse_pkg::seed_bit(SEED, (1 << d) + i))
      ) u_node (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .x   (flat[IN_LO +: K + 1]),
        .lo  (flat[OUT_LO +: K]),
        .hi  (flat[OUT_LO + K +: K])
      );
    end
  end

  assign elem_nxt = flat[tse_pkg::lvl_off(LAYERS, LAYERS) +: N];
endmodule

// File: rtl/tree_shaper_enc.sv
module tree_shaper_enc #(
  parameter int          LAYERS = 3,
  parameter logic [15:0] SEED   = 16'hACE1,
  localparam int         N      = 1 << LAYERS,
  localparam int         CW     = LAYERS + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [CW-1:0] in_count,
  output logic [N-1:0]  elem
);
  logic [N-1:0] elem_nxt;

  tse_tree #(
    .LAYERS (LAYERS),
    .SEED   (SEED)
  ) u_tree (
    .clk      (clk),
    .rst      (rst),
    .en       (in_valid),
    .count    (in_count),
    .elem_nxt (elem_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)           elem <= '0;
    else if (in_valid) elem <= elem_nxt;
  end
endmodule

// File: rtl/tree_shaper_enc_chk.sv
module tree_shaper_enc_chk #(
  parameter  int LAYERS = 3,
  localparam int N      = 1 << LAYERS,
  localparam int CW     = LAYERS + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [CW-1:0] in_count,
  input logic [N-1:0]  elem
);
  int lo_n, hi_n;
  always_comb begin
    lo_n = $countones(elem[N/2-1:0]);
    hi_n = $countones(elem[N-1:N/2]);
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> elem == '0);

  // R2
  ones_sum_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> $countones(elem) == int'($past(in_count)));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(elem));

  // R4
  root_balance_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (lo_n - hi_n <= 1) && (hi_n - lo_n <= 1));

  // R6
  even_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_count[0]) |=> lo_n == hi_n);

  // R8
  in_range_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> in_count <= CW'(N));
endmodule

bind tree_shaper_enc tree_shaper_enc_chk #(.LAYERS(LAYERS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_count (in_count),
  .elem     (elem)
);

// File: tb/tb_tree_shaper_enc.sv
module tb_tree_shaper_enc;
  localparam int LAYERS = 3;
  localparam int N      = 1 << LAYERS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [LAYERS:0]  in_count = '0;
  logic [N-1:0]     elem;

  int checks = 0;
  int errors = 0;
  int last_s [1:N-1];
  bit done = 1'b0;

  tree_shaper_enc #(.LAYERS(LAYERS)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_count(in_count), .elem(elem)
  );

  function automatic int grp(input logic [N-1:0] v, input int st, input int sz);
    int c;
    c = 0;
    for (int e = st; e < st + sz; e++) c += int'(v[e]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_track();
    for (int j = 1; j < N; j++) last_s[j] = 0;
  endtask

  task automatic check_tree(input int v);
    chk(grp(elem, 0, N) == v, "R2", "ones in elem", grp(elem, 0, N), v);
    for (int d = 0; d < LAYERS; d++) begin
      for (int i = 0; i < (1 << d); i++) begin
        int k, lo, hi, j;
        k  = LAYERS - d;
        j  = (1 << d) + i;
        lo = grp(elem, i * (1 << k), 1 << (k - 1));
        hi = grp(elem, i * (1 << k) + (1 << (k - 1)), 1 << (k - 1));
        chk((lo - hi <= 1) && (hi - lo <= 1), "R4", "half difference", lo - hi, 0);
        if (((lo + hi) % 2) == 1) begin
          if (last_s[j] != 0)
            chk((lo - hi) != last_s[j], "R5", "sign repeat at node", lo - hi, -last_s[j]);
          last_s[j] = lo - hi;
        end else begin
          chk(lo == hi, "R6", "even split", lo - hi, 0);
        end
      end
    end
  endtask

  task automatic apply(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_count = (LAYERS + 1)'(v);
    @(negedge clk);
    in_valid = 1'b0;
    in_count = (LAYERS + 1)'($urandom_range(0, 15));
    check_tree(v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(elem == '0, "R1", "elem during reset", int'(elem), 0);
    rst = 1'b0;
    clear_track();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0] saved;
    int use_cnt [N];

    do_reset();
    @(negedge clk);
    chk(elem == '0, "R1", "elem after reset", int'(elem), 0);

    // every ordered pair of legal counts
    for (int a = 0; a <= N; a++)
      for (int b = 0; b <= N; b++) begin
        apply(a);
        apply(b);
      end

    // R3: idle cycles with changing count leave elem untouched
    apply(5);
    saved = elem;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      in_count = (LAYERS + 1)'($urandom_range(0, 15));
      chk(elem == saved, "R3", "elem while idle", int'(elem), int'(saved));
    end

    // R7: runs of 1 and of 7
    for (int e = 0; e < N; e++) use_cnt[e] = 0;
    for (int n = 0; n < N; n++) begin
      apply(1);
      for (int e = 0; e < N; e++) use_cnt[e] += int'(elem[e]);
    end
    for (int e = 0; e < N; e++)
      chk(use_cnt[e] == 1, "R7", "uses in run of ones", use_cnt[e], 1);

    for (int e = 0; e < N; e++) use_cnt[e] = 0;
    for (int n = 0; n < N; n++) begin
      apply(N - 1);
      for (int e = 0; e < N; e++) use_cnt[e] += int'(!elem[e]);
    end
    for (int e = 0; e < N; e++)
      chk(use_cnt[e] == 1, "R7", "idle slots in run of sevens", use_cnt[e], 1);

    // reset in the middle of a run, then random traffic
    do_reset();
    @(negedge clk);
    chk(elem == '0, "R1", "elem after second reset", int'(elem), 0);
    for (int n = 0; n < 400; n++) begin
      apply($urandom_range(0, N));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule